// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recently used address translations close to the pipeline. Each slot holds a virtual page number as its tag. Its payload is a whole page table entry: a physical frame number in the upper bits and a group of property bits in the lower bits. A lookup presents a virtual address. The page number part is compared against every valid slot at once. On a hit, the block returns the physical address in the same cycle, made of the cached frame number followed by the untouched page offset, together with the property bits.

When nothing matches, the block raises a miss and exposes the page number that a refill source outside the block must resolve. That source later hands back a tag and an entry to install. The slot for a new page is chosen in this order: a free slot first, otherwise the slot used least recently.

Two controls keep the contents consistent with the tables in memory. A single-page invalidate drops the one slot whose tag matches, if there is one. A load of a new translation base empties the whole array in one cycle.

Top module: `tlb_xlate_cache`

## Requirements
- R1: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high in the same cycle. `lk_hit` is high only when a valid slot's tag equals `lk_va[VA_W-1:OFF_W]`. While `lk_valid` is low, both are low.
- R2: On a hit, `lk_pa` equals the cached frame number (entry bits `[PTE_W-1:PROP_W]`) followed by `lk_va[OFF_W-1:0]`, and `lk_prop` equals entry bits `[PROP_W-1:0]`.
- R3: The slot count `ENTRIES` is a parameter in the range 16 to 48, with a default of 32. The array holds that many distinct translations at once.
- R4: A pulse on `inv_valid` removes only the slot whose tag equals `inv_vpn`. If no slot matches, nothing changes.
- R5: A cycle with `base_load` high empties every slot. A lookup in that same cycle reports a miss. A refill in that same cycle is dropped.
- R6: A refill of a page that is not present goes to a free slot if any slot is free. Only when every slot is valid does it replace the least recently used one.
- R7: Both a lookup hit and a refill make the touched slot the most recently used. The replacement order is true LRU.
- R8: A lookup and a refill of the same page in the same cycle give a miss in that cycle and a hit from the next cycle on.
- R9: A refill whose tag is already present overwrites that slot's entry in place. It never creates a second copy.
- R10: After a synchronous reset, every slot is invalid, so every lookup misses.
- R11: During a miss, `miss_vpn` carries the page number of the lookup for the refill source. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VPN_W+OFF_W | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a valid translation |
| lk_miss | output | 1 | Lookup found nothing; request to refill source |
| lk_pa | output | PFN_W+OFF_W | Translated physical address |
| lk_prop | output | PROP_W | Property bits of the hit entry |
| miss_vpn | output | VPN_W | Page number to resolve on a miss |
| rf_valid | input | 1 | Refill entry present |
| rf_vpn | input | VPN_W | Tag of the refill entry |
| rf_pte | input | PFN_W+PROP_W | Entry to install, frame number in the upper bits |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vpn | input | VPN_W | Page number to invalidate |
| base_load | input | 1 | New translation base loaded; empty the array |

## Verification
The bench runs with the smallest legal array of 16 slots. It checks every lookup against a reference that keeps a last-use timestamp for each page. First comes an ordered fill of all slots followed by a sweep of hits, which shows that capacity, the address split and the payload mux are correct. Directed sequences then single out each case. Eviction after a hit has reordered the slots separates true LRU from fill order. An invalidate followed by a refill shows that a free slot is taken before an eviction. A rewrite of a present page exposes duplicate tags. A flush or a refill that shares a cycle with a lookup checks the same-cycle priorities. A long pseudo-random mix over more pages than slots then exercises eviction, invalidation and flush together.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int MIN_ENTRIES = 16;
  localparam int MAX_ENTRIES = 48;

  // which event promotes a slot to most recently used this cycle
  typedef enum logic [1:0] {
    TOUCH_NONE = 2'd0,
    TOUCH_HIT  = 2'd1,
    TOUCH_FILL = 2'd2
  } touch_src_e;
endpackage

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
// Parallel tag compare against every slot, masked by the valid bits
module tlb_match #(
  parameter int N     = 32,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [N-1:0]            vld,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_lru.sv
`timescale 1ns/1ps
// True LRU by per-slot age ranks (0 = most recent, N-1 = least recent).
// The ranks always form a permutation of 0..N-1.
module tlb_lru #(
  parameter int N     = 32,
  parameter int AGE_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     vld,
  input  logic             touch_en,
  input  logic [AGE_W-1:0] touch_idx,
  output logic [AGE_W-1:0] victim_idx
);
  logic [AGE_W-1:0] age_q [N];
  logic [AGE_W-1:0] touch_age;
  logic [AGE_W-1:0] inv_idx;
  logic [AGE_W-1:0] old_idx;
  logic             any_free;

  assign touch_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= AGE_W'(i);
    end else if (touch_en) begin
      for (int j = 0; j < N; j++) begin
        if (AGE_W'(j) == touch_idx)   age_q[j] <= '0;
        else if (age_q[j] < touch_age) age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  // lowest free slot, and the slot holding the oldest rank
  always_comb begin
    inv_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        inv_idx  = AGE_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    old_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == AGE_W'(N - 1)) old_idx = AGE_W'(i);
    end
  end

  assign victim_idx = any_free ? inv_idx : old_idx;
endmodule

// File: rtl/tlb_xlate_cache.sv
`timescale 1ns/1ps
module tlb_xlate_cache #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int PROP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VPN_W+OFF_W-1:0]  lk_va,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic [PFN_W+OFF_W-1:0]  lk_pa,
  output logic [PROP_W-1:0]       lk_prop,
  output logic [VPN_W-1:0]        miss_vpn,
  input  logic                    rf_valid,
  input  logic [VPN_W-1:0]        rf_vpn,
  input  logic [PFN_W+PROP_W-1:0] rf_pte,
  input  logic                    inv_valid,
  input  logic [VPN_W-1:0]        inv_vpn,
  input  logic                    base_load
);
  import tlb_pkg::*;

  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PTE_W = PFN_W + PROP_W;
  localparam int IDX_W = $clog2(ENTRIES);

  if (ENTRIES < MIN_ENTRIES || ENTRIES > MAX_ENTRIES) begin : g_bad_size
    $error("tlb_xlate_cache: ENTRIES outside supported range");
  end

  logic [ENTRIES-1:0][VPN_W-1:0] tags_q;
  logic [ENTRIES-1:0][PTE_W-1:0] ptes_q;
  logic [ENTRIES-1:0]            vld_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [OFF_W-1:0]   lk_off;
  logic [ENTRIES-1:0] lk_hvec, rf_hvec, inv_hvec;
  logic [PTE_W-1:0]   lk_pte;
  logic [IDX_W-1:0]   lk_idx, rf_hit_idx, rf_slot, victim_idx, touch_idx;
  logic               lk_any, fill_en, touch_en;
  touch_src_e         touch_src;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];
  assign lk_off = lk_va[OFF_W-1:0];

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .tags(tags_q), .vld(vld_q), .key(lk_vpn), .hit(lk_hvec)
  );
  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_rf_match (
    .tags(tags_q), .vld(vld_q), .key(rf_vpn), .hit(rf_hvec)
  );
  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_inv_match (
    .tags(tags_q), .vld(vld_q), .key(inv_vpn), .hit(inv_hvec)
  );

  // one-hot select of the hit entry and index encoders
  always_comb begin
    lk_pte     = '0;
    lk_idx     = '0;
    rf_hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hvec[i]) begin
        lk_pte = lk_pte | ptes_q[i];
        lk_idx = IDX_W'(i);
      end
      if (rf_hvec[i]) rf_hit_idx = IDX_W'(i);
    end
  end

  assign lk_any   = |lk_hvec;
  assign lk_hit   = lk_valid && lk_any && !base_load;
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_pa    = {lk_pte[PTE_W-1:PROP_W], lk_off};
  assign lk_prop  = lk_pte[PROP_W-1:0];
  assign miss_vpn = lk_miss ? lk_vpn : '0;

  assign fill_en = rf_valid && !base_load;
  assign rf_slot = (|rf_hvec) ? rf_hit_idx : victim_idx;

  always_comb begin
    if (fill_en)     touch_src = TOUCH_FILL;
    else if (lk_hit) touch_src = TOUCH_HIT;
    else             touch_src = TOUCH_NONE;
  end

  assign touch_en  = (touch_src != TOUCH_NONE);
  assign touch_idx = (touch_src == TOUCH_FILL) ? rf_slot : lk_idx;

  tlb_lru #(.N(ENTRIES), .AGE_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .vld(vld_q),
    .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(victim_idx)
  );

  // valid bits: reset and flush clear; invalidate clears one; fill sets one
  always_ff @(posedge clk) begin
    if (rst || base_load) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_en && rf_slot == IDX_W'(i)) vld_q[i] <= 1'b1;
        else if (inv_valid && inv_hvec[i])  vld_q[i] <= 1'b0;
      end
    end
  end

  // tag and payload storage carries no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_en && rf_slot == IDX_W'(i)) begin
        tags_q[i] <= rf_vpn;
        ptes_q[i] <= rf_pte;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   lk_valid,
  input logic [VPN_W+OFF_W-1:0] lk_va,
  input logic                   lk_hit,
  input logic                   lk_miss,
  input logic [PFN_W+OFF_W-1:0] lk_pa,
  input logic [VPN_W-1:0]       miss_vpn,
  input logic                   rf_valid,
  input logic                   inv_valid,
  input logic                   base_load,
  input logic [ENTRIES-1:0]     vld
);
  AST_LK_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> (lk_hit ^ lk_miss)); // R1
  AST_LK_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R1
  AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0])); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    base_load |=> (vld == '0)); // R5
  AST_FLUSH_LOOKUP_MISS: assert property (@(posedge clk) disable iff (rst)
    (base_load && lk_valid) |-> lk_miss); // R5
  AST_INV_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !rf_valid && !base_load) |=> ($countones(vld) <= $past($countones(vld)))); // R4
  AST_FILL_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
    (rf_valid && !base_load) |=> (vld != '0)); // R6
  AST_MISS_REQ_VPN: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (miss_vpn == lk_va[VPN_W+OFF_W-1:OFF_W])); // R11
endmodule

bind tlb_xlate_cache tlb_xlate_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .miss_vpn(miss_vpn),
  .rf_valid(rf_valid), .inv_valid(inv_valid), .base_load(base_load),
  .vld(vld_q)
);

// File: tb/tb_tlb_xlate_cache.sv
`timescale 1ns/1ps
module tb_tlb_xlate_cache;
  localparam int N      = 16;
  localparam int VPN_W  = 20;
  localparam int OFF_W  = 12;
  localparam int PFN_W  = 20;
  localparam int PROP_W = 8;
  localparam int KEYS   = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, rf_valid = 1'b0, inv_valid = 1'b0, base_load = 1'b0;
  logic [VPN_W+OFF_W-1:0]  lk_va = '0;
  logic [VPN_W-1:0]        rf_vpn = '0, inv_vpn = '0;
  logic [PFN_W+PROP_W-1:0] rf_pte = '0;
  logic                    lk_hit, lk_miss;
  logic [PFN_W+OFF_W-1:0]  lk_pa;
  logic [PROP_W-1:0]       lk_prop;
  logic [VPN_W-1:0]        miss_vpn;

  always #2 clk = ~clk; // 250 MHz

  tlb_xlate_cache #(.ENTRIES(N), .VPN_W(VPN_W), .OFF_W(OFF_W),
                    .PFN_W(PFN_W), .PROP_W(PROP_W)) dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .lk_prop(lk_prop),
    .miss_vpn(miss_vpn), .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pte(rf_pte),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .base_load(base_load)
  );

  int n_run = 0, n_fail = 0;
  int now = 0;
  int gen = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  // reference: presence, payload and last-use time per page key
  bit                m_pres [KEYS];
  logic [PFN_W-1:0]  m_pfn  [KEYS];
  logic [PROP_W-1:0] m_prop [KEYS];
  int                m_ts   [KEYS];

  function automatic logic [VPN_W-1:0] kv(input int k);
    return VPN_W'(k * 37 + 5);
  endfunction

  function automatic int m_count();
    int c = 0;
    for (int k = 0; k < KEYS; k++) if (m_pres[k]) c++;
    return c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input bit lv, input logic [VPN_W+OFF_W-1:0] va,
                       input bit rv, input logic [VPN_W-1:0] rvpn,
                       input logic [PFN_W+PROP_W-1:0] rpte,
                       input bit iv, input logic [VPN_W-1:0] ivpn, input bit bl);
    @(negedge clk);
    lk_valid = lv; lk_va = va; rf_valid = rv; rf_vpn = rvpn; rf_pte = rpte;
    inv_valid = iv; inv_vpn = ivpn; base_load = bl;
    now++;
    #1;
  endtask

  task automatic model_fill(input int k, input logic [PFN_W-1:0] pfn,
                            input logic [PROP_W-1:0] pr);
    if (!m_pres[k] && m_count() == N) begin
      int v = -1;
      for (int j = 0; j < KEYS; j++)
        if (m_pres[j] && (v < 0 || m_ts[j] < m_ts[v])) v = j;
      m_pres[v] = 1'b0;
    end
    m_pres[k] = 1'b1; m_pfn[k] = pfn; m_prop[k] = pr; m_ts[k] = now;
  endtask

  task automatic do_lookup(input int k, input string req);
    logic [OFF_W-1:0] off = OFF_W'(k * 291 + now);
    drive(1'b1, {kv(k), off}, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    chk(req, "hit", 64'(lk_hit), 64'(m_pres[k]));
    if (m_pres[k]) begin
      chk(req, "pa", 64'(lk_pa), 64'({m_pfn[k], off}));
      chk(req, "prop", 64'(lk_prop), 64'(m_prop[k]));
      m_ts[k] = now;
    end else begin
      chk(req, "miss_vpn", 64'(miss_vpn), 64'(kv(k)));
    end
  endtask

  task automatic do_fill(input int k);
    logic [PFN_W-1:0]  pfn;
    logic [PROP_W-1:0] pr;
    gen++;
    pfn = PFN_W'(k * 4099 + gen * 17 + 1);
    pr  = PROP_W'(k * 29 + gen);
    drive(1'b0, '0, 1'b1, kv(k), {pfn, pr}, 1'b0, '0, 1'b0);
    model_fill(k, pfn, pr);
  endtask

  task automatic do_inv(input int k);
    drive(1'b0, '0, 1'b0, '0, '0, 1'b1, kv(k), 1'b0);
    m_pres[k] = 1'b0;
  endtask

  task automatic sweep(input int hi, input string req);
    for (int k = 0; k < hi; k++) do_lookup(k, req);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < KEYS; k++) begin m_pres[k] = 1'b0; m_ts[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 / R11: empty after reset, misses expose the page number
    for (int k = 0; k < 4; k++) do_lookup(k, "R10");
    drive(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    chk("R1", "idle hit", 64'(lk_hit), 64'd0);
    chk("R1", "idle miss", 64'(lk_miss), 64'd0);

    // R3 / R2 / R1: fill every slot, all must translate
    for (int k = 0; k < N; k++) do_fill(k);
    sweep(N, "R2");
    chk("R3", "resident count", 64'(m_count()), 64'(N));

    // R7: reorder by a hit, then eviction must take the oldest page (key 0)
    do_lookup(3, "R7");
    do_fill(20);
    do_lookup(0, "R7");
    chk("R7", "key0 evicted", 64'(lk_hit), 64'd0);
    do_lookup(3, "R7");
    chk("R7", "key3 kept", 64'(lk_hit), 64'd1);
    do_lookup(1, "R7");
    do_fill(21);
    do_lookup(1, "R7");
    chk("R7", "key1 kept after hit", 64'(lk_hit), 64'd1);
    do_lookup(2, "R7");
    chk("R7", "key2 evicted", 64'(lk_hit), 64'd0);

    // R4: single-page invalidate, and invalidate of an absent page
    do_inv(5);
    do_lookup(5, "R4");
    do_inv(40);
    sweep(24, "R4");

    // R6: the freed slot is reused, no resident page is lost
    do_fill(22);
    sweep(24, "R6");

    // R9: rewriting a resident page replaces its entry in place
    do_fill(22);
    do_lookup(22, "R9");
    do_fill(23);
    sweep(24, "R9");

    // R8: lookup and refill of one page in the same cycle
    begin
      logic [PFN_W-1:0] pfn = 20'hABCDE;
      drive(1'b1, {kv(30), 12'h123}, 1'b1, kv(30), {pfn, 8'h5A}, 1'b0, '0, 1'b0);
      chk("R8", "same-cycle miss", 64'(lk_miss), 64'd1);
      model_fill(30, pfn, 8'h5A);
      do_lookup(30, "R8");
      chk("R8", "next-cycle hit", 64'(lk_hit), 64'd1);
    end

    // R5: flush with a lookup of a resident page in the same cycle
    drive(1'b1, {kv(30), 12'h456}, 1'b0, '0, '0, 1'b0, '0, 1'b1);
    chk("R5", "lookup during flush", 64'(lk_miss), 64'd1);
    for (int k = 0; k < KEYS; k++) m_pres[k] = 1'b0;
    sweep(32, "R5");
    // R5: a refill in the flush cycle is dropped
    drive(1'b0, '0, 1'b1, kv(7), 28'h1234567, 1'b0, '0, 1'b1);
    do_lookup(7, "R5");

    // mixed pseudo-random traffic over more pages than slots
    for (int n = 0; n < 1500; n++) begin
      int k, op;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      k  = int'(lfsr[12:8]) % 24;
      op = int'(lfsr[7:0]);
      if (op < 120)      do_lookup(k, "R7");
      else if (op < 220) do_fill(k);
      else if (op < 252) do_inv(k);
      else begin
        drive(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b1);
        for (int j = 0; j < KEYS; j++) m_pres[j] = 1'b0;
      end
    end
    sweep(24, "R6");

    drive(1'b0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule